// File: doc/BRIEF.md
# CAN Interrupt Gating and Priority Encoder

This block gathers every interrupt source of a CAN controller onto one interrupt request line toward the host. There is one status source and a bank of message objects, fifteen by default. The status source is fed by the controller's status logic. Its error part is raised by the bus-off and warning flags. Its status-change part is raised by the reception-done flag, the transmission-done flag and a non-zero last-error code. Each message object keeps its own pending flag. A transmit or receive completion sets that flag when the object's matching enable is on, and a host clear pulse removes it.

The block applies two levels of enable. A per-source enable decides whether a request becomes pending at all. A global enable decides only whether pending work drives the interrupt line. With the global enable off, the pending code still tracks the sources. The host reads an 8-bit code that names the single highest-ranked pending source. It clears that source and reads again until the code returns zero. The ranking is irregular: status comes first, then the last message object, then objects 1 upward in falling rank. Both the code and the line come from registers, recomputed every clock.

Top module: `can_irq_arbiter`

## Requirements
- R1: During and straight after synchronous reset, `irq` is 0, `irq_code` is 00h and all `obj_pnd` bits are 0.
- R2: The status source is pending while `err_en` is 1 and `bus_off` or `warn_lvl` is 1. With `err_en` at 0 these two flags make nothing pending.
- R3: The status source is also pending while `stat_en` is 1 and any of `rx_ok`, `tx_ok` or a non-zero `last_err` holds. With `stat_en` at 0 these make nothing pending.
- R4: `obj_pnd[i]` (object i+1) sets one cycle after `obj_tx_done[i]` with `obj_txie[i]` set, or after `obj_rx_done[i]` with `obj_rxie[i]` set. A completion whose enable bit is 0 leaves the flag at 0.
- R5: A set `obj_pnd[i]` holds until an `obj_pnd_clr[i]` pulse and is 0 the cycle after it. When a set event and a clear arrive in the same cycle, the set wins.
- R6: `irq_code` is 00h with nothing pending, 01h for status, 02h for the last object (object 15), and 02h+k for object k (k = 1..14). When several sources are pending, it shows the lowest non-zero code among them.
- R7: `irq` is 1 exactly when the previous cycle had `glb_en` = 1 and some source pending. With `glb_en` = 0, `irq_code` still reports pending sources while `irq` stays 0.
- R8: A change on the status inputs or on `glb_en` reaches `irq_code` and `irq` one cycle later. An object completion reaches `obj_pnd` one cycle later and reaches `irq_code` and `irq` two cycles later.
- R9: One reception with `stat_en` and the object's receive enable both set gives two pending requests. The code reads 01h first. Once `rx_ok` drops, it reads that object's code until the object is cleared, and then it reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable, gates the line only |
| err_en | input | 1 | Enable for bus-off and warning requests |
| stat_en | input | 1 | Enable for status-change requests |
| bus_off | input | 1 | Bus-off flag from status logic |
| warn_lvl | input | 1 | Error-warning flag from status logic |
| rx_ok | input | 1 | Reception-done flag (held until host clears it) |
| tx_ok | input | 1 | Transmission-done flag (held until host clears it) |
| last_err | input | 3 | Last error code, non-zero counts as a status change |
| obj_txie | input | 15 | Per-object transmit interrupt enable |
| obj_rxie | input | 15 | Per-object receive interrupt enable |
| obj_tx_done | input | 15 | Per-object transmit completion pulse |
| obj_rx_done | input | 15 | Per-object receive completion pulse |
| obj_pnd_clr | input | 15 | Per-object host clear pulse for the pending flag |
| obj_pnd | output | 15 | Per-object pending flags |
| irq | output | 1 | Registered interrupt request to the host |
| irq_code | output | 8 | Registered code of highest-ranked pending source |

## Verification
The vector table drives the error flags, the status-change flags and the error code each under its own enable, then alone without it. This shows that the two per-source enables are separate. Object completions are driven as single objects at both ends and in the middle of the bank, and as groups that hold object 15 together with low-numbered objects. This sets the irregular ranking apart from a plain index order. The same object patterns are repeated with the global enable off, which shows whether pending state and line gating are kept apart. Directed sequences check the one-cycle and two-cycle output latency, the set-over-clear collision and the two requests left by a single reception.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int CODE_W = 8;
  localparam int LEC_W  = 3;

  localparam logic [CODE_W-1:0] CODE_NONE = 8'h00;
  localparam logic [CODE_W-1:0] CODE_STAT = 8'h01;
  localparam logic [CODE_W-1:0] CODE_TOP  = 8'h02;

  // Code of message object k (1-based) in a bank of n objects.
  function automatic logic [CODE_W-1:0] obj_code(input int k, input int n);
    if (k == n) return CODE_TOP;
    return CODE_W'(k + 2);
  endfunction

endpackage

// File: rtl/can_irq_stat_src.sv
module can_irq_stat_src
  import can_irq_pkg::*;
(
  input  logic             err_en,
  input  logic             stat_en,
  input  logic             bus_off,
  input  logic             warn_lvl,
  input  logic             rx_ok,
  input  logic             tx_ok,
  input  logic [LEC_W-1:0] last_err,
  output logic             stat_req
);

  logic err_hit;
  logic chg_hit;

  always_comb begin
    err_hit  = err_en  & (bus_off | warn_lvl);
    chg_hit  = stat_en & (rx_ok | tx_ok | (|last_err));
    stat_req = err_hit | chg_hit;
  end

endmodule

// File: rtl/can_irq_obj_flags.sv
module can_irq_obj_flags #(
  parameter int NUM_OBJ = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] txie,
  input  logic [NUM_OBJ-1:0] rxie,
  input  logic [NUM_OBJ-1:0] tx_done,
  input  logic [NUM_OBJ-1:0] rx_done,
  input  logic [NUM_OBJ-1:0] clr,
  output logic [NUM_OBJ-1:0] pnd
);

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    logic set_ev;
    logic flag_q;

    always_comb set_ev = (tx_done[i] & txie[i]) | (rx_done[i] & rxie[i]);

    always_ff @(posedge clk) begin
      if (rst)         flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;   // a new event beats a clear
      else if (clr[i]) flag_q <= 1'b0;
    end

    assign pnd[i] = flag_q;
  end

endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  logic               stat_req,
  input  logic [NUM_OBJ-1:0] obj_pnd,
  output logic [CODE_W-1:0]  code
);

  always_comb begin
    code = CODE_NONE;
    // Lowest-ranked first, so later hits override earlier ones.
    for (int k = NUM_OBJ - 1; k >= 1; k--) begin
      if (obj_pnd[k-1]) code = obj_code(k, NUM_OBJ);
    end
    if (obj_pnd[NUM_OBJ-1]) code = CODE_TOP;
    if (stat_req)           code = CODE_STAT;
  end

endmodule

// File: rtl/can_irq_arbiter.sv
module can_irq_arbiter
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               err_en,
  input  logic               stat_en,
  input  logic               bus_off,
  input  logic               warn_lvl,
  input  logic               rx_ok,
  input  logic               tx_ok,
  input  logic [LEC_W-1:0]   last_err,
  input  logic [NUM_OBJ-1:0] obj_txie,
  input  logic [NUM_OBJ-1:0] obj_rxie,
  input  logic [NUM_OBJ-1:0] obj_tx_done,
  input  logic [NUM_OBJ-1:0] obj_rx_done,
  input  logic [NUM_OBJ-1:0] obj_pnd_clr,
  output logic [NUM_OBJ-1:0] obj_pnd,
  output logic               irq,
  output logic [CODE_W-1:0]  irq_code
);

  localparam int MAX_CODE = NUM_OBJ + 1;

  initial begin
    if (NUM_OBJ < 2 || MAX_CODE >= (1 << CODE_W))
      $error("can_irq_arbiter: NUM_OBJ out of range");
  end

  logic              stat_req;
  logic [CODE_W-1:0] code_d;

  can_irq_stat_src u_stat (
    .err_en   (err_en),
    .stat_en  (stat_en),
    .bus_off  (bus_off),
    .warn_lvl (warn_lvl),
    .rx_ok    (rx_ok),
    .tx_ok    (tx_ok),
    .last_err (last_err),
    .stat_req (stat_req)
  );

  can_irq_obj_flags #(.NUM_OBJ(NUM_OBJ)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .txie    (obj_txie),
    .rxie    (obj_rxie),
    .tx_done (obj_tx_done),
    .rx_done (obj_rx_done),
    .clr     (obj_pnd_clr),
    .pnd     (obj_pnd)
  );

  can_irq_prio #(.NUM_OBJ(NUM_OBJ)) u_prio (
    .stat_req (stat_req),
    .obj_pnd  (obj_pnd),
    .code     (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_code <= CODE_NONE;
      irq      <= 1'b0;
    end else begin
      irq_code <= code_d;
      irq      <= glb_en & (code_d != CODE_NONE);
    end
  end

endmodule

// File: rtl/can_irq_arbiter_chk.sv
module can_irq_arbiter_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               glb_en,
  input logic [NUM_OBJ-1:0] obj_txie,
  input logic [NUM_OBJ-1:0] obj_rxie,
  input logic [NUM_OBJ-1:0] obj_tx_done,
  input logic [NUM_OBJ-1:0] obj_rx_done,
  input logic [NUM_OBJ-1:0] obj_pnd_clr,
  input logic [NUM_OBJ-1:0] obj_pnd,
  input logic               irq,
  input logic [CODE_W-1:0]  irq_code
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && irq_code == CODE_NONE && obj_pnd == '0));

  assert_set_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    ((obj_pnd & ~$past(obj_pnd)) &
     ~$past((obj_tx_done & obj_txie) | (obj_rx_done & obj_rxie))) == '0);

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(obj_pnd & ~obj_pnd_clr) & ~obj_pnd) == '0);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    irq_code <= CODE_W'(NUM_OBJ + 1));

  assert_top_obj_code_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_code == CODE_TOP) |-> $past(obj_pnd[NUM_OBJ-1]));

  assert_irq_has_code_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_code != CODE_NONE && $past(glb_en)));

  assert_irq_when_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_code != CODE_NONE && $past(glb_en)) |-> irq);

endmodule

bind can_irq_arbiter can_irq_arbiter_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (.*);

// File: tb/can_irq_arbiter_bench.sv
module can_irq_arbiter_bench;

  localparam int N = 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         glb_en = 0, err_en = 0, stat_en = 0;
  logic         bus_off = 0, warn_lvl = 0, rx_ok = 0, tx_ok = 0;
  logic [2:0]   last_err = '0;
  logic [N-1:0] obj_txie = '0, obj_rxie = '0;
  logic [N-1:0] obj_tx_done = '0, obj_rx_done = '0, obj_pnd_clr = '0;
  logic [N-1:0] obj_pnd;
  logic         irq;
  logic [7:0]   irq_code;

  always #2 clk = ~clk;   // 250 MHz

  can_irq_arbiter #(.NUM_OBJ(N)) u_can_irq_arbiter (.*);

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic       g, e, s, bo, wn, rxo, txo;
    logic [2:0] lec;
    logic [N-1:0] ie;      // transmit enables, bit 0 = object 1
    logic [N-1:0] ev;      // transmit completion pulse
    logic [7:0] code;
    logic       irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h0000,15'h0000,8'h00,1'b0}, // idle
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,15'h0000,15'h0000,8'h01,1'b1}, // R2 bus-off
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,15'h0000,15'h0000,8'h00,1'b0}, // R2 masked
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,15'h0000,15'h0000,8'h01,1'b1}, // R3 lec
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0,15'h0000,15'h0000,8'h00,1'b0}, // R3 masked
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h7FFF,15'h0001,8'h03,1'b1}, // R6 obj1
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h7FFF,15'h4001,8'h02,1'b1}, // R6 obj15 first
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h7FFF,15'h2000,8'h10,1'b1}, // R6 obj14
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h3FFF,15'h7FFF,8'h03,1'b1}, // R4 obj15 off
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h7FFF,15'h0100,8'h0B,1'b0}, // R7 obj9 gated
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,15'h7FFF,15'h4000,8'h01,1'b0}, // R7 status gated
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,3'd0,15'h7FFF,15'h0010,8'h01,1'b1}, // R6 status over obj5
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,15'h0FF0,15'h00F0,8'h07,1'b1}  // R6 obj5..8
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    glb_en = 0; err_en = 0; stat_en = 0; bus_off = 0; warn_lvl = 0;
    rx_ok = 0; tx_ok = 0; last_err = '0; obj_txie = '0; obj_rxie = '0;
    obj_pnd_clr = '1;
    tick(1);
    obj_pnd_clr = '0;
    tick(2);
  endtask

  initial begin
    tick(3);
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 code in reset", 32'(irq_code), 0);
    rst = 0;
    tick(1);
    chk("R1 code after reset", 32'(irq_code), 0);
    chk("R1 pnd after reset", 32'(obj_pnd), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      clear_all();
      glb_en = VECS[v].g; err_en = VECS[v].e; stat_en = VECS[v].s;
      bus_off = VECS[v].bo; warn_lvl = VECS[v].wn; rx_ok = VECS[v].rxo;
      tx_ok = VECS[v].txo; last_err = VECS[v].lec; obj_txie = VECS[v].ie;
      obj_tx_done = VECS[v].ev;
      tick(1);
      obj_tx_done = '0;
      tick(2);
      chk($sformatf("R6 code vec %0d", v), 32'(irq_code), 32'(VECS[v].code));
      chk($sformatf("R7 irq vec %0d", v), 32'(irq), 32'(VECS[v].irq));
      chk($sformatf("R4 pnd vec %0d", v), 32'(obj_pnd), 32'(VECS[v].ie & VECS[v].ev));
    end

    // R8 latency of status path
    clear_all();
    glb_en = 1; err_en = 1; bus_off = 1;
    tick(1);
    chk("R8 status code after 1", 32'(irq_code), 32'h01);
    chk("R8 status irq after 1", 32'(irq), 1);
    bus_off = 0;
    tick(1);
    chk("R8 status drop after 1", 32'(irq_code), 0);

    // R8 latency of object path (object 2 receive)
    obj_rxie = 15'h0002; obj_rx_done = 15'h0002;
    tick(1);
    obj_rx_done = '0;
    chk("R8 flag after 1", 32'(obj_pnd), 32'h0002);
    chk("R8 code not yet", 32'(irq_code), 0);
    tick(1);
    chk("R8 code after 2", 32'(irq_code), 32'h04);
    chk("R8 irq after 2", 32'(irq), 1);

    // R5 hold, set-over-clear, clear
    tick(5);
    chk("R5 flag holds", 32'(obj_pnd), 32'h0002);
    obj_rx_done = 15'h0002; obj_pnd_clr = 15'h0002;
    tick(1);
    obj_rx_done = '0; obj_pnd_clr = '0;
    chk("R5 set wins over clear", 32'(obj_pnd), 32'h0002);
    obj_pnd_clr = 15'h0002;
    tick(1);
    obj_pnd_clr = '0;
    chk("R5 cleared", 32'(obj_pnd), 0);
    tick(1);
    chk("R5 code after clear", 32'(irq_code), 0);
    chk("R5 irq after clear", 32'(irq), 0);

    // R9 one reception, two requests (object 3)
    clear_all();
    glb_en = 1; stat_en = 1; obj_rxie = 15'h0004;
    rx_ok = 1; obj_rx_done = 15'h0004;
    tick(1);
    obj_rx_done = '0;
    tick(1);
    chk("R9 status first", 32'(irq_code), 32'h01);
    chk("R9 object flag", 32'(obj_pnd), 32'h0004);
    rx_ok = 0;
    tick(1);
    chk("R9 object next", 32'(irq_code), 32'h05);
    chk("R9 irq still up", 32'(irq), 1);
    obj_pnd_clr = 15'h0004;
    tick(1);
    obj_pnd_clr = '0;
    tick(1);
    chk("R9 none at end", 32'(irq_code), 0);
    chk("R9 irq down", 32'(irq), 0);

    // R1 reset in the middle of activity
    obj_txie = '1; obj_tx_done = '1; err_en = 1; warn_lvl = 1;
    tick(1);
    obj_tx_done = '0;
    rst = 1;
    tick(1);
    chk("R1 pnd under reset", 32'(obj_pnd), 0);
    chk("R1 irq under reset", 32'(irq), 0);
    rst = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule